// File: doc/BRIEF.md
# Reciprocal Frequency Meter

This block measures an unknown input frequency by relating a whole number of input periods to a span of system clocks. The input is synchronised, and only its rising edges are counted. The first edge after reset, or after a timeout, opens a measurement window. That edge fixes a timestamp taken from a free-running clock counter. Each later edge advances the count. The window closes on the first edge at which the count since the window opened reaches the programmed target. On that edge the block reports four values: the whole cycles counted, the elapsed clocks, the clocks spent high and the clocks spent low. It marks the report with a one-cycle strobe.

The closing edge opens the next window at once, so consecutive reports tile time without a gap. Downstream logic forms the frequency as cycles divided by clocks, and the duty cycle as high clocks over total clocks. The division itself is not part of the block. A watchdog on edge activity raises a no-input flag when the input stops toggling. When it fires, it discards the window in progress.

Top module: `recip_freq_meter`

## Requirements
- R1: During and right after reset, all result outputs are zero, `meas_valid` is low and `no_input` is low.
- R2: Only rising input edges are counted. For a steady input, `meas_cycles` equals the effective target, which is the number of whole periods in the window.
- R3: `meas_clks` equals the number of system clocks between the rising edge that opened the window and the rising edge that closed it. This is target × period for a steady input.
- R4: `meas_high` counts the system clocks of the window during which the synchronised input was high. `meas_low` equals `meas_clks - meas_high`.
- R5: A `target_cycles` value of 0 behaves exactly like a target of 1.
- R6: The edge that closes a window also opens the next one. On a steady input, consecutive reports are identical.
- R7: If `target_cycles` is lowered below the count already reached, the next rising edge closes the window. That report carries the actual edge count, which is above the target, and the elapsed clocks that match it.
- R8: `meas_valid` is high for exactly one cycle per closed window. All result outputs hold their values between strobes.
- R9: `no_input` goes high once `timeout_clks` consecutive cycles pass without a detected rising edge. The next detected rising edge clears it.
- R10: When the timeout expires, the open window is discarded. The next edge only opens a fresh window and produces no report.
- R11: If a rising edge is detected in the cycle in which the timeout would expire, the edge wins. `no_input` stays low and the window continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also advances the timestamp counter |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_in | input | 1 | Asynchronous input whose frequency is measured |
| target_cycles | input | CNT_W | Whole periods per window (0 treated as 1) |
| timeout_clks | input | TIME_W | Clocks without an edge before `no_input` is raised |
| meas_valid | output | 1 | One-cycle strobe: new results available |
| meas_cycles | output | CNT_W | Rising edges counted in the closed window |
| meas_clks | output | TIME_W | System clocks spanned by the closed window |
| meas_high | output | TIME_W | Clocks the input was high within the window |
| meas_low | output | TIME_W | Clocks the input was low within the window |
| no_input | output | 1 | Input activity timed out |

## Verification
A detected rising edge and an expiring timeout can fall in the same cycle, and the edge must win. The bench provokes this by setting `timeout_clks` equal to the input period, so the idle counter reaches its limit exactly on each edge. It then checks that `no_input` never rises and that reports keep arriving with exact values. As a contrast, the period is made one clock longer than the timeout. Here the flag must rise before every edge and no report may ever close. A window close can also coincide with the edge that opens the next window. This is judged by requiring back-to-back reports on a steady input to be identical.

// File: rtl/rfm_pkg.sv
package rfm_pkg;
   localparam int unsigned DEF_CNT_W  = 32;
   localparam int unsigned DEF_TIME_W = 32;
   localparam int unsigned DEF_SYNC   = 2;

   typedef enum logic {
      WIN_IDLE = 1'b0,
      WIN_OPEN = 1'b1
   } win_state_t;
endpackage

// File: rtl/rfm_edge_sync.sv
module rfm_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic level,
   output logic rise
);
   logic [STAGES-1:0] chain;
   logic              level_d;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= din;
         end
      end else begin : g_multi
         always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], din};
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) level_d <= 1'b0;
      else        level_d <= chain[STAGES-1];
   end

   assign level = chain[STAGES-1];
   assign rise  = chain[STAGES-1] & ~level_d;
endmodule

// File: rtl/rfm_idle_watch.sv
module rfm_idle_watch #(
   parameter int unsigned TIME_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rise,
   input  logic [TIME_W-1:0] limit,
   output logic              expire,
   output logic              no_input
);
   localparam logic [TIME_W-1:0] IDLE_MAX = '1;

   logic [TIME_W-1:0] idle_q;
   logic [TIME_W:0]   idle_inc;

   assign idle_inc = {1'b0, idle_q} + 1'b1;
   assign expire   = !rise && !no_input && (idle_inc >= {1'b0, limit});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idle_q   <= '0;
         no_input <= 1'b0;
      end else if (rise) begin
         idle_q   <= '0;
         no_input <= 1'b0;
      end else begin
         if (idle_q != IDLE_MAX) idle_q <= idle_q + 1'b1;
         if (expire)             no_input <= 1'b1;
      end
   end
endmodule

// File: rtl/rfm_window.sv
module rfm_window
   import rfm_pkg::*;
#(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned TIME_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rise,
   input  logic              level,
   input  logic              expire,
   input  logic [CNT_W-1:0]  target,
   input  logic [TIME_W-1:0] stamp,
   output logic              res_valid,
   output logic [CNT_W-1:0]  res_cycles,
   output logic [TIME_W-1:0] res_clks,
   output logic [TIME_W-1:0] res_high,
   output logic [TIME_W-1:0] res_low
);
   win_state_t        state_q;
   logic [TIME_W-1:0] open_stamp;
   logic [CNT_W-1:0]  edges_q;
   logic [TIME_W-1:0] high_q;
   logic [CNT_W-1:0]  goal;
   logic [CNT_W:0]    edges_inc;
   logic [TIME_W-1:0] span;
   logic              closing;

   assign goal      = (target == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : target;
   assign edges_inc = {1'b0, edges_q} + 1'b1;
   assign span      = stamp - open_stamp;
   assign closing   = rise && (state_q == WIN_OPEN) && (edges_inc >= {1'b0, goal});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= WIN_IDLE;
         open_stamp <= '0;
         edges_q    <= '0;
         high_q     <= '0;
         res_valid  <= 1'b0;
         res_cycles <= '0;
         res_clks   <= '0;
         res_high   <= '0;
         res_low    <= '0;
      end else begin
         res_valid <= 1'b0;
         if (closing) begin
            res_valid  <= 1'b1;
            res_cycles <= edges_inc[CNT_W-1:0];
            res_clks   <= span;
            res_high   <= high_q;
            res_low    <= span - high_q;
            open_stamp <= stamp;
            edges_q    <= '0;
            high_q     <= {{(TIME_W-1){1'b0}}, 1'b1};
         end else if (rise && state_q == WIN_OPEN) begin
            edges_q <= edges_inc[CNT_W-1:0];
            high_q  <= high_q + 1'b1;
         end else if (rise) begin
            state_q    <= WIN_OPEN;
            open_stamp <= stamp;
            edges_q    <= '0;
            high_q     <= {{(TIME_W-1){1'b0}}, 1'b1};
         end else if (expire) begin
            state_q <= WIN_IDLE;
         end else if (state_q == WIN_OPEN && level) begin
            high_q <= high_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/recip_freq_meter.sv
module recip_freq_meter
   import rfm_pkg::*;
#(
   parameter int unsigned CNT_W       = DEF_CNT_W,
   parameter int unsigned TIME_W      = DEF_TIME_W,
   parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sig_in,
   input  logic [CNT_W-1:0]  target_cycles,
   input  logic [TIME_W-1:0] timeout_clks,
   output logic              meas_valid,
   output logic [CNT_W-1:0]  meas_cycles,
   output logic [TIME_W-1:0] meas_clks,
   output logic [TIME_W-1:0] meas_high,
   output logic [TIME_W-1:0] meas_low,
   output logic              no_input
);
   generate
      if (CNT_W < 2 || CNT_W > 64) begin : g_bad_cnt
         $error("CNT_W must lie in 2..64");
      end
      if (TIME_W < 4 || TIME_W > 64) begin : g_bad_time
         $error("TIME_W must lie in 4..64");
      end
      if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 1..4");
      end
   endgenerate

   logic              sync_level;
   logic              edge_rise;
   logic              idle_expire;
   logic [TIME_W-1:0] stamp_q;

   always_ff @(posedge clk) begin
      if (!rst_n) stamp_q <= '0;
      else        stamp_q <= stamp_q + 1'b1;
   end

   rfm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (sig_in),
      .level (sync_level),
      .rise  (edge_rise)
   );

   rfm_idle_watch #(.TIME_W(TIME_W)) u_idle (
      .clk      (clk),
      .rst_n    (rst_n),
      .rise     (edge_rise),
      .limit    (timeout_clks),
      .expire   (idle_expire),
      .no_input (no_input)
   );

   rfm_window #(.CNT_W(CNT_W), .TIME_W(TIME_W)) u_win (
      .clk        (clk),
      .rst_n      (rst_n),
      .rise       (edge_rise),
      .level      (sync_level),
      .expire     (idle_expire),
      .target     (target_cycles),
      .stamp      (stamp_q),
      .res_valid  (meas_valid),
      .res_cycles (meas_cycles),
      .res_clks   (meas_clks),
      .res_high   (meas_high),
      .res_low    (meas_low)
   );
endmodule

// File: rtl/rfm_checker.sv
module rfm_checker #(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned TIME_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rise,
   input logic              no_input,
   input logic              meas_valid,
   input logic [CNT_W-1:0]  meas_cycles,
   input logic [TIME_W-1:0] meas_clks,
   input logic [TIME_W-1:0] meas_high,
   input logic [TIME_W-1:0] meas_low
);
   a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      meas_valid |=> !meas_valid);

   a_r8_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !meas_valid |-> ($stable(meas_cycles) && $stable(meas_clks) && $stable(meas_high)));

   a_r2_close_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
      meas_valid |-> $past(rise));

   a_r5_nonzero_count: assert property (@(posedge clk) disable iff (!rst_n)
      meas_valid |-> (meas_cycles != '0));

   a_r4_high_within_span: assert property (@(posedge clk) disable iff (!rst_n)
      meas_valid |-> (meas_high <= meas_clks && meas_low <= meas_clks));

   a_r9_edge_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !no_input);

   a_r10_no_report_after_timeout: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && no_input) |=> !meas_valid);
endmodule

bind recip_freq_meter rfm_checker #(.CNT_W(CNT_W), .TIME_W(TIME_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rise        (edge_rise),
   .no_input    (no_input),
   .meas_valid  (meas_valid),
   .meas_cycles (meas_cycles),
   .meas_clks   (meas_clks),
   .meas_high   (meas_high),
   .meas_low    (meas_low)
);

// File: tb/recip_freq_meter_tb_top.sv
module recip_freq_meter_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int CW = 32;
   localparam int TW = 32;
   localparam int NVEC = 6;
   // columns: high clocks, low clocks, target
   localparam int VEC [NVEC][3] = '{
      '{3, 3, 4}, '{5, 2, 8}, '{1, 1, 16}, '{10, 7, 1}, '{2, 9, 0}, '{4, 4, 35}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sig_in = 1'b0;
   logic [CW-1:0] target_cycles = '0;
   logic [TW-1:0] timeout_clks = '0;
   logic          meas_valid;
   logic [CW-1:0] meas_cycles;
   logic [TW-1:0] meas_clks;
   logic [TW-1:0] meas_high;
   logic [TW-1:0] meas_low;
   logic          no_input;

   int  n_total = 0;
   int  n_fail  = 0;
   int  cyc     = 0;
   bit  gen_en  = 1'b0;
   int  gen_h   = 1;
   int  gen_l   = 1;
   int  gen_ph  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   recip_freq_meter #(.CNT_W(CW), .TIME_W(TW)) dut_i (
      .clk(clk), .rst_n(rst_n), .sig_in(sig_in),
      .target_cycles(target_cycles), .timeout_clks(timeout_clks),
      .meas_valid(meas_valid), .meas_cycles(meas_cycles), .meas_clks(meas_clks),
      .meas_high(meas_high), .meas_low(meas_low), .no_input(no_input)
   );

   // input waveform generator, driven on falling edges
   initial begin
      forever begin
         @(negedge clk);
         if (!gen_en) begin
            sig_in = 1'b0;
            gen_ph = 0;
         end else begin
            sig_in = (gen_ph < gen_h);
            gen_ph = (gen_ph + 1 == gen_h + gen_l) ? 0 : gen_ph + 1;
         end
      end
   end

   task automatic chk(input string req, input longint act, input longint exp);
      n_total++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      gen_en = 1'b0;
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wait_valid(input int limit, output bit seen);
      seen = 1'b0;
      for (int i = 0; i < limit; i++) begin
         @(negedge clk);
         if (meas_valid) begin
            seen = 1'b1;
            break;
         end
      end
   endtask

   // watchdog
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_total++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("%0d/%0d checks passed", n_total - n_fail, n_total);
         $finish;
      end
   end

   initial begin
      bit seen;
      int nv;
      bit flag_seen;
      longint c_hold, k_hold;

      // R1: reset state
      timeout_clks = 1000;
      @(negedge clk);
      chk("R1 valid in reset", meas_valid, 0);
      chk("R1 cycles in reset", meas_cycles, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 clks after reset", meas_clks, 0);
      chk("R1 high after reset", meas_high, 0);
      chk("R1 no_input after reset", no_input, 0);

      // vector table: R2 R3 R4 R5 R6 R8
      for (int v = 0; v < NVEC; v++) begin
         int h, l, n, ne;
         h = VEC[v][0]; l = VEC[v][1]; n = VEC[v][2];
         ne = (n == 0) ? 1 : n;
         do_reset();
         target_cycles = n;
         timeout_clks = 1000;
         gen_h = h; gen_l = l; gen_en = 1'b1;
         for (int w = 0; w < 2; w++) begin
            wait_valid(ne * (h + l) + 40, seen);
            chk("R8 strobe seen", seen, 1);
            chk((n == 0) ? "R5 zero target cycles" : "R2 cycles", meas_cycles, ne);
            chk((w == 1) ? "R6 back-to-back clks" : "R3 clks", meas_clks, ne * (h + l));
            chk("R4 high clocks", meas_high, ne * h);
            chk("R4 low clocks", meas_low, ne * l);
         end
         c_hold = meas_cycles; k_hold = meas_clks;
         @(negedge clk);
         chk("R8 strobe one cycle", meas_valid, 0);
         chk("R8 cycles held", meas_cycles, c_hold);
         chk("R8 clks held", meas_clks, k_hold);
      end

      // R9 / R10: timeout and window abandonment
      do_reset();
      target_cycles = 4; timeout_clks = 50;
      gen_h = 3; gen_l = 3; gen_en = 1'b1;
      wait_valid(100, seen);
      chk("R9 strobe before silence", seen, 1);
      gen_en = 1'b0;
      nv = 0;
      for (int i = 0; i < 70; i++) begin
         @(negedge clk);
         if (meas_valid) nv++;
      end
      chk("R9 flag after silence", no_input, 1);
      chk("R10 no report while silent", nv, 0);
      gen_en = 1'b1;
      repeat (10) @(negedge clk);
      chk("R9 flag cleared by edge", no_input, 0);
      wait_valid(100, seen);
      chk("R10 fresh window cycles", meas_cycles, 4);
      chk("R10 fresh window clks", meas_clks, 24);

      // R7: late close after target lowered
      do_reset();
      target_cycles = 20; timeout_clks = 1000;
      gen_h = 2; gen_l = 2; gen_en = 1'b1;
      wait_valid(150, seen);
      chk("R7 first strobe", seen, 1);
      repeat (30) @(negedge clk);
      target_cycles = 3;
      wait_valid(20, seen);
      chk("R7 late strobe", seen, 1);
      chk("R7 count above target", (meas_cycles > 3), 1);
      chk("R7 clks match count", meas_clks, meas_cycles * 4);
      chk("R7 high match count", meas_high, meas_cycles * 2);

      // R11: edge in the expiry cycle wins
      do_reset();
      target_cycles = 2; timeout_clks = 8;
      gen_h = 4; gen_l = 4; gen_en = 1'b1;
      nv = 0; flag_seen = 1'b0;
      for (int i = 0; i < 150; i++) begin
         @(negedge clk);
         if (no_input) flag_seen = 1'b1;
         if (meas_valid) begin
            nv++;
            chk("R11 clks with coincident expiry", meas_clks, 16);
         end
      end
      chk("R11 flag stays low", flag_seen, 0);
      chk("R11 reports keep coming", (nv >= 5), 1);

      // contrast: period one clock longer than the timeout
      do_reset();
      target_cycles = 2; timeout_clks = 7;
      gen_h = 4; gen_l = 4; gen_en = 1'b1;
      nv = 0; flag_seen = 1'b0;
      for (int i = 0; i < 150; i++) begin
         @(negedge clk);
         if (no_input) flag_seen = 1'b1;
         if (meas_valid) nv++;
      end
      chk("R9 flag rises between edges", flag_seen, 1);
      chk("R10 every window discarded", nv, 0);

      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end
endmodule